// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the event flags that a USB host controller core raises for software. The core sends a one-cycle pulse for each of five events: a system error unrelated to USB traffic, a resume from a downstream device, the start of a frame, the done-queue head landing in shared memory, and a scheduling overrun. Each pulse sets a sticky flag. Software reads the flags through a small register port and clears a flag by writing 1 to its bit. A level interrupt output is raised when any flag that is enabled by both its own mask bit and the master enable is set.

The block does two jobs besides holding the flags. First, it grants the core permission to write the done-queue head back to memory. It withdraws that permission while the writeback flag is still set, so software's copy of the previous head is not overwritten before software has saved it. Second, it counts scheduling overruns in a small wrapping counter that software can read separately.

Top module: `usb_hc_intstat`

## Requirements
- R1: After reset the flags, the enable mask, the master enable and the overrun counter are all 0. `irq` is 0 and `wb_permit` is 1.
- R2: A read at address 0 returns the flags at these bit positions: bit 4 system error, bit 3 resume detected, bit 2 start of frame, bit 1 done-head writeback, bit 0 scheduling overrun. Bits 31:5 read as 0.
- R3: A write at address 0 clears each flag whose data bit is 1. A data bit of 0 leaves that flag unchanged.
- R4: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: `ev_sys_err` sets bit 4. Bit 4 then stays set, through any further events, until software clears it.
- R6: `ev_resume` sets bit 3 only while `sw_resume_active` is 0. While `sw_resume_active` is 1, the pulse is ignored.
- R7: `ev_sof` sets bit 2 only when `fn_updated` is 1 in the same cycle. Without `fn_updated`, the pulse is ignored.
- R8: `ev_wdh` sets bit 1. `wb_permit` is 0 from the next cycle onward, for as long as bit 1 is set, and returns to 1 once bit 1 is cleared.
- R9: `ev_overrun` sets bit 0 and adds one to a 2-bit overrun counter that wraps modulo 4. The counter reads at address 2 in bits 1:0; all other bits there read as 0.
- R10: Address 1 is a read/write enable register: bits 4:0 are a per-flag mask and bit 31 is the master enable. Its other bits are not stored and read as 0.
- R11: `irq` is 1 exactly when the master enable is 1 and at least one set flag has its mask bit set.
- R12: A write to address 3 changes no state, and a read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_sys_err | input | 1 | System error pulse |
| ev_resume | input | 1 | Downstream resume pulse |
| sw_resume_active | input | 1 | High while software is driving the resume state |
| ev_sof | input | 1 | Frame start pulse |
| fn_updated | input | 1 | Frame number update complete, qualifies `ev_sof` |
| ev_wdh | input | 1 | Done-head writeback complete pulse |
| ev_overrun | input | 1 | Scheduling overrun pulse |
| wb_permit | output | 1 | Core may write the done-queue head back |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench steps through every set pattern of the five flags against every clear pattern, and through every mask under both master enable values. A decode with swapped bit positions, or a clear that hits the wrong bits, would show up as a wrong read value. Targeted cases cover a set pulse and a clearing write in the same cycle, which a clear-wins design would lose. They also cover resume during software resume and a start-of-frame pulse without the frame-number qualifier; a design that failed to gate these would set the flag. The bench follows the overrun counter across its wrap from 3 to 0 and confirms that the writeback permit stays low until the flag is cleared, not merely for one cycle. It also checks that writes to the unused address leave both the flags and the enable register untouched.

// File: rtl/usb_hc_intstat.sv
module usb_hc_intstat #(
  parameter int DATA_W  = 32,
  parameter int NFLAG   = 5,
  parameter int OVR_W   = 2,
  parameter int MST_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sys_err,
  input  logic              ev_resume,
  input  logic              sw_resume_active,
  input  logic              ev_sof,
  input  logic              fn_updated,
  input  logic              ev_wdh,
  input  logic              ev_overrun,
  output logic              wb_permit,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_OVR  = 2'd2;
  localparam int B_UE = 4, B_RD = 3, B_SF = 2, B_WD = 1, B_SO = 0;

  logic [NFLAG-1:0] flags_q, set_v, clr_v;
  logic [NFLAG-1:0] mask_q;
  logic             master_q;
  logic [OVR_W-1:0] ovr_cnt_q;

  assign set_v[B_UE] = ev_sys_err;
  assign set_v[B_RD] = ev_resume & ~sw_resume_active;
  assign set_v[B_SF] = ev_sof & fn_updated;
  assign set_v[B_WD] = ev_wdh;
  assign set_v[B_SO] = ev_overrun;

  assign clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      master_q <= 1'b0;
    end else if (reg_wr && reg_addr == A_EN) begin
      mask_q   <= reg_wdata[NFLAG-1:0];
      master_q <= reg_wdata[MST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_cnt_q <= '0;
    else if (ev_overrun) ovr_cnt_q <= ovr_cnt_q + 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[NFLAG-1:0] = flags_q;
      A_EN: begin
        reg_rdata[NFLAG-1:0] = mask_q;
        reg_rdata[MST_BIT]   = master_q;
      end
      A_OVR:  reg_rdata[OVR_W-1:0] = ovr_cnt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = master_q & |(flags_q & mask_q);
  assign wb_permit = ~flags_q[B_WD];
endmodule

module usb_hc_intstat_chk #(
  parameter int DATA_W = 32,
  parameter int NFLAG  = 5,
  parameter int OVR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_sys_err,
  input logic              ev_resume,
  input logic              sw_resume_active,
  input logic              ev_sof,
  input logic              fn_updated,
  input logic              ev_wdh,
  input logic              ev_overrun,
  input logic              wb_permit,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [NFLAG-1:0]  flags_q,
  input logic [OVR_W-1:0]  ovr_cnt_q
);
  logic clr_ue;
  assign clr_ue = reg_wr && reg_addr == 2'd0 && reg_wdata[4];

  AST_UE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) ev_sys_err |=> flags_q[4]); // R4
  AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flags_q[4] && !clr_ue) |=> flags_q[4]); // R5
  AST_RESUME_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (!flags_q[3] && sw_resume_active) |=> !flags_q[3]); // R6
  AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) (!flags_q[2] && !fn_updated) |=> !flags_q[2]); // R7
  AST_WB_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) ev_wdh |=> !wb_permit); // R8
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n) ev_overrun |=> ovr_cnt_q == $past(ovr_cnt_q) + 1'b1); // R9
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ev_overrun |=> $stable(ovr_cnt_q)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> flags_q != '0); // R11
endmodule

bind usb_hc_intstat usb_hc_intstat_chk #(.DATA_W(DATA_W), .NFLAG(NFLAG), .OVR_W(OVR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_sys_err(ev_sys_err), .ev_resume(ev_resume),
  .sw_resume_active(sw_resume_active), .ev_sof(ev_sof), .fn_updated(fn_updated),
  .ev_wdh(ev_wdh), .ev_overrun(ev_overrun), .wb_permit(wb_permit), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .flags_q(flags_q),
  .ovr_cnt_q(ovr_cnt_q)
);

// File: tb/usb_hc_intstat_tb_top.sv
`timescale 1ns/1ps
module usb_hc_intstat_tb_top;
  logic clk = 0, rst_n = 0;
  logic ev_sys_err = 0, ev_resume = 0, sw_resume_active = 0, ev_sof = 0, fn_updated = 0;
  logic ev_wdh = 0, ev_overrun = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic wb_permit, irq;
  int total = 0, bad = 0, cyc = 0;
  int cnt_exp = 0;
  logic done = 0;

  always #4 clk = ~clk;

  usb_hc_intstat dut_i (
    .clk(clk), .rst_n(rst_n), .ev_sys_err(ev_sys_err), .ev_resume(ev_resume),
    .sw_resume_active(sw_resume_active), .ev_sof(ev_sof), .fn_updated(fn_updated),
    .ev_wdh(ev_wdh), .ev_overrun(ev_overrun), .wb_permit(wb_permit), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fire(input logic [4:0] p);
    ev_sys_err = p[4]; ev_resume = p[3]; sw_resume_active = 0;
    ev_sof = p[2]; fn_updated = p[2]; ev_wdh = p[1]; ev_overrun = p[0];
    step();
    if (p[0]) cnt_exp = (cnt_exp + 1) % 4;
    ev_sys_err = 0; ev_resume = 0; ev_sof = 0; fn_updated = 0; ev_wdh = 0; ev_overrun = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(); step();
    rst_n = 1;
    step();
    rd(0, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 enable", d, 0);
    rd(2, d); chk("R1 count", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 permit", {31'b0, wb_permit}, 1);

    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 32; c++) begin
        wr(0, 32'h1f);
        fire(p[4:0]);
        rd(0, d); chk("R2 set pattern", d, p);
        chk("R8 permit", {31'b0, wb_permit}, {31'b0, ~p[1]});
        wr(0, 32'hffff_ffe0 | c);
        rd(0, d); chk("R3 clear pattern", d, p & ~c);
        rd(2, d); chk("R9 counter", d, cnt_exp);
      end
    end

    for (int p = 0; p < 32; p++) begin
      wr(0, 32'h1f);
      fire(p[4:0]);
      for (int m = 0; m < 64; m++) begin
        wr(1, {m[5], 26'h3ff_ffff, m[4:0]});
        rd(1, d); chk("R10 enable readback", d, {m[5], 26'b0, m[4:0]});
        chk("R11 irq", {31'b0, irq}, {31'b0, m[5] & |(p[4:0] & m[4:0])});
      end
    end

    wr(1, 0);
    wr(0, 32'h1f);
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h10; ev_sys_err = 1;
    step();
    reg_wr = 0; ev_sys_err = 0;
    rd(0, d); chk("R4 set beats clear", d, 32'h10);
    fire(5'h0f); wr(0, 32'h0f);
    rd(0, d); chk("R5 error sticky", d, 32'h10);
    wr(0, 0);
    rd(0, d); chk("R3 write zero", d, 32'h10);
    wr(0, 32'h10);

    ev_resume = 1; sw_resume_active = 1; step(); ev_resume = 0; sw_resume_active = 0;
    rd(0, d); chk("R6 resume suppressed", d, 0);
    ev_resume = 1; step(); ev_resume = 0;
    rd(0, d); chk("R6 resume sets", d, 32'h08);
    wr(0, 32'h1f);

    ev_sof = 1; fn_updated = 0; step(); ev_sof = 0;
    rd(0, d); chk("R7 sof unqualified", d, 0);
    ev_sof = 1; fn_updated = 1; step(); ev_sof = 0; fn_updated = 0;
    rd(0, d); chk("R7 sof qualified", d, 32'h04);
    wr(0, 32'h1f);

    fire(5'h02);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8 permit held low", {31'b0, wb_permit}, 0);
    end
    wr(0, 32'h02);
    chk("R8 permit restored", {31'b0, wb_permit}, 1);

    for (int k = 0; k < 6; k++) begin
      fire(5'h01);
      rd(2, d); chk("R9 wrap", d, cnt_exp);
    end

    fire(5'h1f);
    wr(1, 32'h8000_001f);
    wr(3, 32'hffff_ffff);
    rd(0, d); chk("R12 flags untouched", d, 32'h1f);
    rd(1, d); chk("R12 enable untouched", d, 32'h8000_001f);
    rd(3, d); chk("R12 read zero", d, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule